// File: doc/BRIEF.md
# Machine Interrupt Pending and Priority Selector

This block gathers the machine-level interrupt sources of a small processor core: one machine timer line and ten platform lines (three GPIO ports with two lines each, a UART receive line, a UART transmit line, and two general timers). Each source is sampled into a pending register on every clock edge. A software-writable enable register masks the pending bits. When the global machine interrupt enable is on and no exception is being raised in the same cycle, the block asks the trap sequencer to take an interrupt and presents the cause code of the winner.

The winner is chosen by fixed priority: the smallest cause code wins. The decision is re-made every cycle from the registered pending bits, the enable register and the two gating inputs. Software reaches the pending and enable registers through a simple CSR read/write port. The pending register follows hardware only, so software writes to it change nothing.

Top module: `irq_pending_arbiter`

## Requirements
- R1: After reset, the enable and pending registers read as zero and `irq_take` is low.
- R2: `timer_irq` is sampled into pending bit 7 on each rising clock edge. The bit follows the level of the input one cycle late, so it sets one cycle after the input rises and clears one cycle after the input falls.
- R3: Platform input `plat_irq[i]` is sampled into pending bit 16+i with the same one-cycle delay. Index 0..9 maps to GPIOA 0, GPIOA 1, GPIOB 0, GPIOB 1, GPIOC 0, GPIOC 1, UART RX, UART TX, timer 0 and timer 1.
- R4: A write to CSR address 0x304 loads the enable register. Only bits 7 and 16..25 store the written value. All other bits always read 0.
- R5: A write to CSR address 0x344 (pending) leaves every pending bit unchanged.
- R6: `irq_take` is high in a cycle exactly when `global_mie` is 1, `exc_active` is 0, and at least one bit is set in both pending and enable. It reacts in the same cycle to changes in those inputs or in the enable register.
- R7: `irq_cause` gives the lowest bit index set in both pending and enable. When `irq_take` is low it is 0.
- R8: When `csr_rd_en` is 1, `csr_rd_data` returns the enable register at 0x304, the pending register at 0x344, and 0 at any other address. When `csr_rd_en` is 0 it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_irq | input | 1 | Machine timer interrupt level |
| plat_irq | input | 10 | Platform interrupt levels, mapped to pending bits 16..25 |
| global_mie | input | 1 | Global machine interrupt enable |
| exc_active | input | 1 | An exception is being raised this cycle |
| csr_rd_en | input | 1 | CSR read enable |
| csr_wr_en | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address |
| csr_wr_data | input | 32 | CSR write data |
| csr_rd_data | output | 32 | CSR read data |
| irq_take | output | 1 | Request to take an interrupt this cycle |
| irq_cause | output | 5 | Cause code of the selected interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit register width, ten platform lines based at bit 16, the timer at bit 7, and CSR addresses 0x304 and 0x344. With these values the highest cause code is 25, which tests the top of the 5-bit cause field. The timer bit sits below every platform bit, so the priority between the timer and the platform lines is tested as well as the priority among neighbouring platform lines. Writing all ones to the enable register shows exactly which eleven bits are implemented.

// File: rtl/irq_pending_arbiter.sv
module irq_pending_arbiter #(
  parameter int XLEN = 32,
  parameter int CSR_AW = 12,
  parameter int N_PLAT = 10,
  parameter int PLAT_BASE = 16,
  parameter int TIMER_BIT = 7,
  parameter logic [CSR_AW-1:0] MIE_ADDR = 12'h304,
  parameter logic [CSR_AW-1:0] MIP_ADDR = 12'h344
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     timer_irq,
  input  logic [N_PLAT-1:0]        plat_irq,
  input  logic                     global_mie,
  input  logic                     exc_active,
  input  logic                     csr_rd_en,
  input  logic                     csr_wr_en,
  input  logic [CSR_AW-1:0]        csr_addr,
  input  logic [XLEN-1:0]          csr_wr_data,
  output logic [XLEN-1:0]          csr_rd_data,
  output logic                     irq_take,
  output logic [$clog2(XLEN)-1:0]  irq_cause
);
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-1:0] PLAT_MASK =
    {{(XLEN-N_PLAT){1'b0}}, {N_PLAT{1'b1}}} << PLAT_BASE;
  localparam logic [XLEN-1:0] IMPL = PLAT_MASK | (XLEN'(1) << TIMER_BIT);

  logic [XLEN-1:0] hw_src, mip_q, mie_q, act;
  logic [CW-1:0]   sel;

  always_comb begin
    hw_src = '0;
    hw_src[TIMER_BIT] = timer_irq;
    hw_src[PLAT_BASE +: N_PLAT] = plat_irq;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mip_q <= '0;
    else        mip_q <= hw_src;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                mie_q <= '0;
    else if (csr_wr_en && csr_addr == MIE_ADDR) mie_q <= csr_wr_data & IMPL;

  assign act = mip_q & mie_q;

  always_comb begin
    sel = '0;
    for (int i = XLEN-1; i >= 0; i--)
      if (act[i]) sel = CW'(i);
  end

  assign irq_take  = global_mie && !exc_active && (act != '0);
  assign irq_cause = irq_take ? sel : '0;

  always_comb begin
    csr_rd_data = '0;
    if (csr_rd_en) begin
      if (csr_addr == MIE_ADDR)      csr_rd_data = mie_q;
      else if (csr_addr == MIP_ADDR) csr_rd_data = mip_q;
    end
  end

  // R2
  timer_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> mip_q[TIMER_BIT]);
  // R2
  timer_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_irq |=> !mip_q[TIMER_BIT]);
  // R4
  mie_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mie_q & ~IMPL) == '0);
  // R4
  mie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr_en && csr_addr == MIE_ADDR) |=> $stable(mie_q));
  // R6
  take_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (mie_q[irq_cause] && mip_q[irq_cause]));
  // R7
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((act & ((XLEN'(1) << irq_cause) - XLEN'(1))) == '0));
  // R7
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> irq_cause == '0);
endmodule

// File: tb/tb_irq_pending_arbiter.sv
`timescale 1ns/1ps
module tb_irq_pending_arbiter;
  logic        clk = 0, rst_n = 0;
  logic        timer_irq = 0, global_mie = 0, exc_active = 0;
  logic [9:0]  plat_irq = '0;
  logic        csr_rd_en = 0, csr_wr_en = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wr_data = '0, csr_rd_data;
  logic        irq_take;
  logic [4:0]  irq_cause;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [11:0] A_MIE = 12'h304, A_MIP = 12'h344;
  localparam logic [31:0] IMPL = 32'h03FF_0080;

  irq_pending_arbiter dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [31:0] rd(input logic [11:0] a);
    return 32'h0;
  endfunction

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
    csr_rd_en = 1; csr_addr = a; #1; d = csr_rd_data; csr_rd_en = 0; #1;
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    csr_wr_en = 1; csr_addr = a; csr_wr_data = d; tick(); csr_wr_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    csr_read(A_MIE, d); chk("R1 mie", d, 0);
    csr_read(A_MIP, d); chk("R1 mip", d, 0);
    chk("R1 take", irq_take, 0);
  endtask

  task automatic t_mie_rw();
    logic [31:0] d;
    csr_write(A_MIE, 32'hFFFF_FFFF);
    csr_read(A_MIE, d); chk("R4 all ones", d, IMPL);
    csr_write(A_MIE, 32'h0000_0000);
    csr_read(A_MIE, d); chk("R4 zero", d, 0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    timer_irq = 1; #1;
    csr_read(A_MIP, d); chk("R2 before edge", d, 0);
    tick();
    csr_read(A_MIP, d); chk("R2 set", d, 32'h80);
    timer_irq = 0; tick();
    csr_read(A_MIP, d); chk("R2 clear", d, 0);
    plat_irq = 10'h201; tick();
    csr_read(A_MIP, d); chk("R3 plat map", d, 32'h0201_0000);
    plat_irq = 10'h040; tick();
    csr_read(A_MIP, d); chk("R3 uart rx", d, 32'h0040_0000);
    plat_irq = '0; tick();
  endtask

  task automatic t_mip_write();
    logic [31:0] d;
    plat_irq = 10'h004; tick();
    csr_write(A_MIP, 32'hFFFF_FFFF);
    csr_read(A_MIP, d); chk("R5 write all ones", d, 32'h0004_0000);
    csr_write(A_MIP, 32'h0);
    csr_read(A_MIP, d); chk("R5 write zero", d, 32'h0004_0000);
    plat_irq = '0; tick();
  endtask

  task automatic t_gating();
    timer_irq = 1; tick();
    global_mie = 1; #1;
    chk("R6 mie off", irq_take, 0);
    csr_write(A_MIE, 32'h80);
    chk("R6 take", irq_take, 1);
    chk("R7 cause timer", irq_cause, 7);
    exc_active = 1; #1;
    chk("R6 exception blocks", irq_take, 0);
    chk("R7 cause idle", irq_cause, 0);
    exc_active = 0; global_mie = 0; #1;
    chk("R6 global off", irq_take, 0);
    global_mie = 1; #1;
    chk("R6 global on", irq_take, 1);
    timer_irq = 0; #1;
    chk("R6 still pending", irq_take, 1);
    tick();
    chk("R6 dropped", irq_take, 0);
  endtask

  task automatic t_priority();
    csr_write(A_MIE, 32'hFFFF_FFFF);
    plat_irq = 10'h282; timer_irq = 1; tick();
    chk("R7 timer first", irq_cause, 7);
    timer_irq = 0; tick();
    chk("R7 plat 17", irq_cause, 17);
    plat_irq = 10'h280; tick();
    chk("R7 plat 23", irq_cause, 23);
    csr_write(A_MIE, 32'h0200_0000);
    chk("R7 masked to 25", irq_cause, 25);
    csr_write(A_MIE, 32'h0);
    chk("R6 all masked", irq_take, 0);
    plat_irq = '0; tick();
  endtask

  task automatic t_read_port();
    logic [31:0] d;
    timer_irq = 1; tick();
    csr_write(A_MIE, 32'h80);
    csr_rd_en = 0; csr_addr = A_MIE; #1;
    chk("R8 rd disabled", csr_rd_data, 0);
    csr_read(12'h300, d); chk("R8 other addr", d, 0);
    csr_read(A_MIP, d); chk("R8 mip", d, 32'h80);
    timer_irq = 0; tick();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #11 rst_n = 1;
    tick();
    t_reset();
    t_mie_rw();
    t_latency();
    t_mip_write();
    t_gating();
    t_priority();
    t_read_port();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule